// File: doc/BRIEF.md
# I2C Master Clock Phase and Setup Timer

This block sets the pace of the clock line for an I2C master. A 16-bit baud count and a 2-bit speed mode fix the length of the low and high phases. The block pulls the clock line low for the low phase and then releases it. It starts timing the high phase only once it sees the line high. A slave that holds the clock low therefore stretches the period and does not shorten the high phase. After a stretch has ended, a second counter measures a programmable data-setup delay and then gives a one-cycle pulse to the bit engine.

The phase controller is a four-state machine. IDLE is held whenever the baud count is zero. LOW drives the line low. WAIT_HIGH releases the line and waits until it reads high. HIGH keeps the line released for the high count. The transitions are IDLE→LOW when the count becomes non-zero, LOW→WAIT_HIGH when the low count is used up, WAIT_HIGH→HIGH when the line reads high, HIGH→LOW when the high count is used up, and any state→IDLE when the count is zero. The setup timer has two states. TM_IDLE moves to TM_COUNT when a stretch ends, and TM_COUNT returns to TM_IDLE when the delay expires. The speed mode is encoded 00 standard, 01 fast, 10 fast-plus and 11 high-speed. High-speed has no timing of its own here, so it falls back to standard timing. The clock line input is assumed to be already synchronised to `clk`.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_drive_low`, `low_strobe`, `high_strobe` and `setup_done` are all 0.
- R2: A zero `baud_cnt` stops clock generation. In the cycle after a clock edge that samples zero, `scl_drive_low` is 0, and no strobe appears for as long as the count stays zero. This includes an abort in the middle of a low phase.
- R3: In standard mode (00), with baud count N, each low phase drives `scl_drive_low` for exactly N cycles.
- R4: In fast (01) and fast-plus (10) modes, each low phase lasts exactly 2·N cycles.
- R5: When no slave holds the line, the line stays released for exactly N+1 cycles: one cycle in which the line is seen high, then N cycles of high phase.
- R6: Mode 11 (high-speed) uses standard timing, so the low phase lasts N cycles.
- R7: If a slave holds the line low for S cycles after release, the released interval lasts S+1+N cycles. `high_strobe` appears S+1 cycles after the first released cycle, only after the line has been sampled high.
- R8: After a stretch (S≥1), `setup_done` is a one-cycle pulse exactly max(M,1) cycles after `high_strobe`, where M is `setup_cnt`.
- R9: A release with no stretch produces no `setup_done` pulse.
- R10: `low_strobe` is high only in the first cycle of each low phase, together with `scl_drive_low`. `high_strobe` is high only in the first cycle of the HIGH state. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_mode | input | 2 | 00 standard, 01 fast, 10 fast-plus, 11 high-speed (standard timing) |
| baud_cnt | input | 16 | Phase count N; 0 stops clock generation |
| setup_cnt | input | 16 | Post-stretch data setup delay M in clock cycles (0 acts as 1) |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| low_strobe | output | 1 | Pulse in the first cycle of a low phase |
| high_strobe | output | 1 | Pulse in the first cycle of the high phase |
| setup_done | output | 1 | Pulse when the post-stretch setup delay has elapsed |

## Verification
A phase counter that loads a wrong value shows up within one clock period as a low or released interval of the wrong length, measured directly on `scl_drive_low`. A stretch flag that is lost or set wrongly shows up at the end of the release window, either as a missing `setup_done` or as one that should not be there. The phase and setup delays are timed against `high_strobe`, so a setup counter that is off by one shows up as a shifted pulse within M cycles. Leaving IDLE while the count is zero would drive the line in the very next cycle.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [1:0] {
        SPD_STD   = 2'b00,
        SPD_FAST  = 2'b01,
        SPD_FPLUS = 2'b10,
        SPD_HIGH  = 2'b11
    } spd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_HIGH,
        ST_HIGH
    } phase_e;

    typedef enum logic {
        TM_IDLE,
        TM_COUNT
    } tmr_e;

endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
    import i2c_scl_pkg::*;
#(
    parameter int BAUD_W = 16,
    parameter int LEN_W  = BAUD_W + 1
) (
    input  logic [1:0]        mode_raw,
    input  logic [BAUD_W-1:0] baud,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len,
    output logic              run_en
);

    spd_mode_e eff_mode;

    // high-speed has no dedicated timing: it falls back to standard
    always_comb begin
        unique case (mode_raw)
            2'b01:   eff_mode = SPD_FAST;
            2'b10:   eff_mode = SPD_FPLUS;
            default: eff_mode = SPD_STD;
        endcase
    end

    always_comb begin
        if (eff_mode == SPD_STD) low_len = {1'b0, baud};
        else                     low_len = {baud, 1'b0};
        high_len = {1'b0, baud};
        run_en   = (baud != '0);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import i2c_scl_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    input  logic             scl_in,
    output logic             drive_low,
    output logic             low_strobe,
    output logic             high_strobe,
    output logic             setup_start
);

    phase_e           st, nxt;
    logic [LEN_W-1:0] cnt, cnt_nxt;
    logic             stretched, stretched_nxt;

    always_comb begin
        nxt           = st;
        cnt_nxt       = cnt;
        stretched_nxt = stretched;
        setup_start   = 1'b0;
        if (!run_en) begin
            nxt           = ST_IDLE;
            cnt_nxt       = '0;
            stretched_nxt = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    nxt     = ST_LOW;
                    cnt_nxt = low_len - 1'b1;
                end
                ST_LOW: begin
                    if (cnt == '0) begin
                        nxt           = ST_WAIT_HIGH;
                        stretched_nxt = 1'b0;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (scl_in) begin
                        nxt           = ST_HIGH;
                        cnt_nxt       = high_len - 1'b1;
                        setup_start   = stretched;
                        stretched_nxt = 1'b0;
                    end else begin
                        stretched_nxt = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt == '0) begin
                        nxt     = ST_LOW;
                        cnt_nxt = low_len - 1'b1;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            stretched <= 1'b0;
        end else begin
            st        <= nxt;
            cnt       <= cnt_nxt;
            stretched <= stretched_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_low   <= 1'b0;
            low_strobe  <= 1'b0;
            high_strobe <= 1'b0;
        end else begin
            drive_low   <= (nxt == ST_LOW);
            low_strobe  <= (nxt == ST_LOW)  && (st != ST_LOW);
            high_strobe <= (nxt == ST_HIGH) && (st != ST_HIGH);
        end
    end

    AST_ZERO_BAUD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !drive_low) else $error("zero count left line driven"); // R2
    AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        high_strobe |-> $past(scl_in)) else $error("high phase before line high"); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_strobe && high_strobe)) else $error("both strobes high"); // R10
    AST_LOW_STROBE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        low_strobe |-> drive_low) else $error("low strobe without drive"); // R10

endmodule

// File: rtl/setup_delay_timer.sv
module setup_delay_timer
    import i2c_scl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] delay,
    output logic             done
);

    tmr_e             st;
    logic [CNT_W-1:0] rem;
    logic             expire;

    assign expire = (st == TM_COUNT) && (rem == CNT_W'(1)) && !start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TM_IDLE;
            rem <= '0;
        end else if (start) begin
            st  <= TM_COUNT;
            rem <= (delay == '0) ? CNT_W'(1) : delay;
        end else begin
            unique case (st)
                TM_IDLE:  rem <= rem;
                TM_COUNT: begin
                    if (rem == CNT_W'(1)) st <= TM_IDLE;
                    else                  rem <= rem - 1'b1;
                end
                default: st <= TM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= expire;
    end

    AST_SETUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("setup pulse wider than one cycle"); // R8
    AST_SETUP_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st == TM_COUNT)) else $error("setup pulse without count"); // R9

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         speed_mode,
    input  logic [BAUD_W-1:0]  baud_cnt,
    input  logic [SETUP_W-1:0] setup_cnt,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               low_strobe,
    output logic               high_strobe,
    output logic               setup_done
);

    localparam int LEN_W = BAUD_W + 1;

    logic [LEN_W-1:0] low_len, high_len;
    logic             run_en, setup_start;

    scl_phase_calc #(.BAUD_W(BAUD_W), .LEN_W(LEN_W)) calc_i (
        .mode_raw (speed_mode),
        .baud     (baud_cnt),
        .low_len  (low_len),
        .high_len (high_len),
        .run_en   (run_en)
    );

    scl_phase_fsm #(.LEN_W(LEN_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .low_len     (low_len),
        .high_len    (high_len),
        .scl_in      (scl_in),
        .drive_low   (scl_drive_low),
        .low_strobe  (low_strobe),
        .high_strobe (high_strobe),
        .setup_start (setup_start)
    );

    setup_delay_timer #(.CNT_W(SETUP_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (setup_start),
        .delay (setup_cnt),
        .done  (setup_done)
    );

endmodule

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  speed_mode = 2'b00;
    logic [15:0] baud_cnt = '0;
    logic [15:0] setup_cnt = '0;
    logic        slave_hold = 1'b0;
    logic        scl_in;
    logic        scl_drive_low, low_strobe, high_strobe, setup_done;

    int n_checks = 0;
    int n_fail   = 0;

    assign scl_in = !scl_drive_low && !slave_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_scl_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .speed_mode    (speed_mode),
        .baud_cnt      (baud_cnt),
        .setup_cnt     (setup_cnt),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .low_strobe    (low_strobe),
        .high_strobe   (high_strobe),
        .setup_done    (setup_done)
    );

    // monitor: slave stretching model and time stamps
    int cyc = 0;
    int stretch_cfg = 0;
    int hold_left = 0;
    logic prev_drive = 1'b0;
    int rel_cyc = -1, hs_cyc = -1, sd_cyc = -1, sd_count = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!scl_drive_low && prev_drive) begin
            rel_cyc   = cyc;
            hold_left = stretch_cfg;
        end
        slave_hold = (hold_left > 0);
        if (hold_left > 0) hold_left = hold_left - 1;
        if (high_strobe) hs_cyc = cyc;
        if (setup_done) begin
            sd_cyc   = cyc;
            sd_count = sd_count + 1;
        end
        prev_drive = scl_drive_low;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_low(input logic [1:0] m, input int n);
        return (m == 2'b01 || m == 2'b10) ? 2 * n : n;
    endfunction

    task automatic run_case(input logic [1:0] m, input int n, input int sdel, input int s);
        int lows, rels, guard, stray, exp_sd;
        string lreq;
        @(negedge clk);
        speed_mode  = m;
        setup_cnt   = 16'(sdel);
        stretch_cfg = s;
        hs_cyc = -1; sd_cyc = -1; sd_count = 0; rel_cyc = -1;
        baud_cnt = 16'(n);
        guard = 0;
        do begin @(negedge clk); guard++; end while (!scl_drive_low && guard < 50);
        chk(low_strobe == 1'b1, "R10 first low strobe", int'(low_strobe), 1);
        lows = 0;
        while (scl_drive_low && lows < 100) begin lows++; @(negedge clk); end
        lreq = (m == 2'b11) ? "R6 low length" : ((m == 2'b00) ? "R3 low length" : "R4 low length");
        chk(lows == exp_low(m, n), lreq, lows, exp_low(m, n));
        rels = 0;
        while (!scl_drive_low && rels < 100) begin rels++; @(negedge clk); end
        chk(rels == s + 1 + n, (s == 0) ? "R5 released length" : "R7 released length", rels, s + 1 + n);
        chk(low_strobe == 1'b1, "R10 next low strobe", int'(low_strobe), 1);
        chk(hs_cyc - rel_cyc == s + 1, "R7 high strobe position", hs_cyc - rel_cyc, s + 1);
        baud_cnt = '0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R2 abort releases line", int'(scl_drive_low), 0);
        stray = 0;
        for (int i = 0; i < sdel + 4; i++) begin
            if (low_strobe || high_strobe || scl_drive_low) stray++;
            @(negedge clk);
        end
        chk(stray == 0, "R2 idle quiet", stray, 0);
        if (s > 0) begin
            exp_sd = (sdel == 0) ? 1 : sdel;
            chk(sd_count == 1, "R8 setup pulse count", sd_count, 1);
            chk(sd_cyc - hs_cyc == exp_sd, "R8 setup delay", sd_cyc - hs_cyc, exp_sd);
        end else begin
            chk(sd_count == 0, "R9 no setup pulse", sd_count, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R1 reset drive", int'(scl_drive_low), 0);
        chk(low_strobe == 1'b0 && high_strobe == 1'b0, "R1 reset strobes",
            int'(low_strobe) + int'(high_strobe), 0);
        chk(setup_done == 1'b0, "R1 reset setup", int'(setup_done), 0);
        repeat (5) @(negedge clk);
        chk(scl_drive_low == 1'b0, "R2 zero count idle", int'(scl_drive_low), 0);

        // directed corners
        run_case(2'b00, 1, 0, 0);   // R3 minimum count, no stretch
        run_case(2'b01, 1, 0, 1);   // R4 fast minimum, M=0 acts as 1
        run_case(2'b10, 3, 2, 2);   // R4 fast-plus
        run_case(2'b11, 4, 5, 3);   // R6 high-speed fallback
        run_case(2'b00, 5, 1, 0);   // R9 no stretch
        run_case(2'b01, 2, 9, 4);   // R8 delay longer than high phase

        for (int k = 0; k < 40; k++) begin
            run_case(2'($urandom_range(0, 3)), $urandom_range(1, 12),
                     $urandom_range(0, 10), $urandom_range(0, 5));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule